// File: doc/BRIEF.md
# Command Timeout and Interrupt Unit

This block sits beside the protocol engines of an external memory controller and watches two things: how long a single command stays open, and how long the bus stays busy on one transaction. Each watch has its own 8-bit setting that selects a limit in multiples of a fixed cycle unit (1024 cycles by default). When a command outlives its limit, the block records a command error and treats the command as finished. When a bus transaction outlives its limit, it records a bus error.

The block also holds the controller's four-bit interrupt status and enable words. Hardware events set status bits, and software clears them by writing ones. The enable word is changed through a masked write that touches only the selected bits. A combined interrupt line reports any enabled pending event. A separate pending flag reports any status bit at all, whatever the enables say. An idle flag shows that no command is open.

Top module: `cmd_watch_irq`

## Requirements
- R1: After reset, status and enable are 0, irq and pending are 0, and idle is 1.
- R2: Status bit positions are: bit 0 command done, bit 1 command error, bit 2 bus-side command error, bit 3 bus error. A one-cycle pulse on cmd_done, cmd_err, xfer_cmd_err or bus_err sets its bit, visible from the next cycle. The bit then stays set until cleared.
- R3: A write with wr_en=1 and wr_sel=1 clears every status bit whose wr_data bit is 1. Bits whose wr_data bit is 0 are left alone, and wr_mask has no effect on this write.
- R4: A write with wr_en=1 and wr_sel=0 loads enable bits from wr_data only where wr_mask is 1. The other enable bits keep their value.
- R5: irq is the OR over all bits of (status AND enable). pending is 1 whenever status is nonzero, regardless of enable.
- R6: idle drops in the cycle after a cmd_start pulse. It returns high after cmd_done or after a command timeout.
- R7: With command setting N (nonzero), the command-error bit sets and idle rises exactly N×2^SCALE_LOG2 cycles after the clock edge that accepted cmd_start, provided no cmd_done came first.
- R8: A setting of zero, for either timer, selects a limit of 255×2^SCALE_LOG2 cycles.
- R9: When bus_busy is sampled high on bus-setting×2^SCALE_LOG2 consecutive edges, the bus-error bit sets. This happens once per busy period. Dropping bus_busy for one cycle restarts the count.
- R10: If a hardware event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R11: A cmd_done that arrives on the edge where the command timer would expire ends the command without a command error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_start | input | 1 | Pulse: a command begins |
| cmd_done | input | 1 | Pulse: the open command completed |
| cmd_err | input | 1 | Pulse: command error from an engine |
| xfer_cmd_err | input | 1 | Pulse: bus-side command error |
| bus_err | input | 1 | Pulse: bus error |
| bus_busy | input | 1 | Level: a bus transaction is in flight |
| cmd_tmo_set | input | 8 | Command timeout setting, in units |
| bus_tmo_set | input | 8 | Bus timeout setting, in units |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = masked enable write, 1 = status clear |
| wr_data | input | 4 | Write data |
| wr_mask | input | 4 | Bit select for enable writes |
| status | output | 4 | Latched event bits |
| enable | output | 4 | Interrupt enable bits |
| irq | output | 1 | Combined interrupt |
| pending | output | 1 | Any status bit set |
| idle | output | 1 | No command open |

## Verification
The properties assume that event inputs are low while reset is held. They also assume that cmd_start and cmd_done are pulses and not held levels, since a held start would keep restarting the command timer. The stimulus drives every input on the falling edge and holds inputs at zero through reset.

Randomized traffic keeps cmd_start and bus_busy low, so the status and enable model never has to predict a timeout. Timeouts, zero settings, the done-on-expiry race and set-versus-clear collisions are driven as directed sequences with settings chosen so the expected edge is known in advance.

// File: rtl/cti_pkg.sv
package cti_pkg;
    localparam int NSRC      = 4;
    localparam int SETTING_W = 8;
    localparam int ZERO_UNITS = 255;

    typedef enum logic [1:0] {
        SRC_DONE    = 2'd0,
        SRC_CMDERR  = 2'd1,
        SRC_XCMDERR = 2'd2,
        SRC_BUSERR  = 2'd3
    } src_e;

    typedef logic [NSRC-1:0] srcvec_t;

    typedef struct packed {
        logic    en;
        logic    sel;
        srcvec_t data;
        srcvec_t mask;
    } regwr_t;

    function automatic logic [31:0] tmo_limit(input logic [SETTING_W-1:0] n,
                                              input int unsigned sh);
        logic [31:0] units;
        units = (n == '0) ? 32'(ZERO_UNITS) : 32'(n);
        return units << sh;
    endfunction
endpackage

// File: rtl/cti_timer.sv
module cti_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == limit - CNT_W'(1));
    assign expire = run && !restart && at_end;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run) begin
            if (at_end) cnt <= '0;
            else        cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/cti_cmd_track.sv
module cti_cmd_track #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             done,
    input  logic [CNT_W-1:0] limit,
    output logic             busy,
    output logic             tmo
);
    logic run;
    assign run = busy && !done;

    cti_timer #(.CNT_W(CNT_W)) i_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (start),
        .run     (run),
        .limit   (limit),
        .expire  (tmo)
    );

    always_ff @(posedge clk) begin
        if (rst)              busy <= 1'b0;
        else if (start)       busy <= 1'b1;
        else if (done || tmo) busy <= 1'b0;
    end
endmodule

// File: rtl/cti_bus_watch.sv
module cti_bus_watch #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic [CNT_W-1:0] limit,
    output logic             tmo
);
    logic fired;
    logic run;
    logic restart;

    assign restart = !busy;
    assign run     = busy && !fired;

    cti_timer #(.CNT_W(CNT_W)) i_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .run     (run),
        .limit   (limit),
        .expire  (tmo)
    );

    always_ff @(posedge clk) begin
        if (rst || !busy) fired <= 1'b0;
        else if (tmo)     fired <= 1'b1;
    end
endmodule

// File: rtl/cti_irq_regs.sv
module cti_irq_regs
    import cti_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  srcvec_t set_vec,
    input  regwr_t  wr,
    output srcvec_t status,
    output srcvec_t enable
);
    srcvec_t clr_vec;
    srcvec_t status_n;
    srcvec_t enable_n;

    always_comb begin
        clr_vec = (wr.en && wr.sel) ? wr.data : '0;
        for (int i = 0; i < NSRC; i++) begin
            status_n[i] = set_vec[i] | (status[i] & ~clr_vec[i]);
            if (wr.en && !wr.sel && wr.mask[i]) enable_n[i] = wr.data[i];
            else                                enable_n[i] = enable[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= status_n;
            enable <= enable_n;
        end
    end
endmodule

// File: rtl/cmd_watch_irq.sv
module cmd_watch_irq
    import cti_pkg::*;
#(
    parameter int SCALE_LOG2 = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_start,
    input  logic       cmd_done,
    input  logic       cmd_err,
    input  logic       xfer_cmd_err,
    input  logic       bus_err,
    input  logic       bus_busy,
    input  logic [7:0] cmd_tmo_set,
    input  logic [7:0] bus_tmo_set,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [3:0] wr_data,
    input  logic [3:0] wr_mask,
    output logic [3:0] status,
    output logic [3:0] enable,
    output logic       irq,
    output logic       pending,
    output logic       idle
);
    localparam int CNT_W = SETTING_W + SCALE_LOG2;

    logic [CNT_W-1:0] cmd_lim;
    logic [CNT_W-1:0] bus_lim;
    logic             cmd_busy;
    logic             cmd_tmo;
    logic             bus_tmo;
    srcvec_t          set_vec;
    regwr_t           wr;

    assign cmd_lim = CNT_W'(tmo_limit(cmd_tmo_set, SCALE_LOG2));
    assign bus_lim = CNT_W'(tmo_limit(bus_tmo_set, SCALE_LOG2));

    cti_cmd_track #(.CNT_W(CNT_W)) i_cmd (
        .clk   (clk),
        .rst   (rst),
        .start (cmd_start),
        .done  (cmd_done),
        .limit (cmd_lim),
        .busy  (cmd_busy),
        .tmo   (cmd_tmo)
    );

    cti_bus_watch #(.CNT_W(CNT_W)) i_bus (
        .clk   (clk),
        .rst   (rst),
        .busy  (bus_busy),
        .limit (bus_lim),
        .tmo   (bus_tmo)
    );

    always_comb begin
        set_vec              = '0;
        set_vec[SRC_DONE]    = cmd_done;
        set_vec[SRC_CMDERR]  = cmd_err | cmd_tmo;
        set_vec[SRC_XCMDERR] = xfer_cmd_err;
        set_vec[SRC_BUSERR]  = bus_err | bus_tmo;
        wr = '{en: wr_en, sel: wr_sel, data: wr_data, mask: wr_mask};
    end

    cti_irq_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .wr      (wr),
        .status  (status),
        .enable  (enable)
    );

    assign irq     = |(status & enable);
    assign pending = |status;
    assign idle    = !cmd_busy;
endmodule

// File: rtl/cti_chk.sv
module cti_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_start,
    input logic       cmd_done,
    input logic       cmd_err,
    input logic       xfer_cmd_err,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [3:0] wr_data,
    input logic [3:0] status,
    input logic [3:0] enable,
    input logic       irq,
    input logic       pending,
    input logic       idle
);
    // R5
    irq_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> pending);
    // R5
    irq_off_when_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (enable == 4'b0) |-> !irq);
    // R2
    done_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmd_done)) |-> status[0]);
    // R2
    xcmd_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(status[2])) |-> $past(xfer_cmd_err));
    // R3
    clear_bit0_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && wr_sel && wr_data[0] && !cmd_done)) |-> !status[0]);
    // R4
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en && !wr_sel)) |-> $stable(enable));
    // R6
    idle_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(idle)) |-> $past(cmd_start));
    // R7
    timeout_ends_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(status[1]) && !$past(cmd_err)) |-> idle);
endmodule

bind cmd_watch_irq cti_chk i_cti_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_start    (cmd_start),
    .cmd_done     (cmd_done),
    .cmd_err      (cmd_err),
    .xfer_cmd_err (xfer_cmd_err),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .status       (status),
    .enable       (enable),
    .irq          (irq),
    .pending      (pending),
    .idle         (idle)
);

// File: tb/test_cmd_watch_irq.sv
`timescale 1ns/1ps
module test_cmd_watch_irq;
    localparam int SH = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_start = 0, cmd_done = 0, cmd_err = 0, xfer_cmd_err = 0, bus_err = 0, bus_busy = 0;
    logic [7:0] cmd_tmo_set = 8'd3, bus_tmo_set = 8'd2;
    logic       wr_en = 0, wr_sel = 0;
    logic [3:0] wr_data = 0, wr_mask = 0;
    logic [3:0] status, enable;
    logic       irq, pending, idle;

    int nrun = 0;
    int nfail = 0;
    bit finished = 0;

    logic [3:0] m_st = 0, m_en = 0;

    always #10 clk = ~clk;

    cmd_watch_irq #(.SCALE_LOG2(SH)) i_cmd_watch_irq (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_done(cmd_done),
        .cmd_err(cmd_err), .xfer_cmd_err(xfer_cmd_err), .bus_err(bus_err),
        .bus_busy(bus_busy), .cmd_tmo_set(cmd_tmo_set), .bus_tmo_set(bus_tmo_set),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_mask(wr_mask),
        .status(status), .enable(enable), .irq(irq), .pending(pending), .idle(idle));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nrun++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] next_st(input logic [3:0] st, input logic [3:0] set,
                                           input logic we, input logic sel, input logic [3:0] d);
        logic [3:0] clr;
        clr = (we && sel) ? d : 4'b0;
        return (st & ~clr) | set;
    endfunction

    function automatic logic [3:0] next_en(input logic [3:0] en, input logic we, input logic sel,
                                           input logic [3:0] d, input logic [3:0] m);
        if (we && !sel) return (en & ~m) | (d & m);
        return en;
    endfunction

    function automatic int lim_of(input logic [7:0] n);
        return ((n == 0) ? 255 : int'(n)) << SH;
    endfunction

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic quiet();
        cmd_start = 0; cmd_done = 0; cmd_err = 0; xfer_cmd_err = 0; bus_err = 0;
        wr_en = 0; wr_sel = 0; wr_data = 0; wr_mask = 0;
    endtask

    task automatic clear_all();
        wr_en = 1; wr_sel = 1; wr_data = 4'hF; cyc(); quiet();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            nrun++; nfail++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        int unsigned seed;
        int lim;
        seed = $urandom(32'd4242);
        repeat (3) cyc();
        rst = 0;
        // R1 reset state
        chk("R1 status", status, 0);
        chk("R1 enable", enable, 0);
        chk("R1 irq", irq, 0);
        chk("R1 pending", pending, 0);
        chk("R1 idle", idle, 1);

        // R2 R3 R4 R5 random traffic, no timers running
        for (int i = 0; i < 400; i++) begin
            logic [3:0] set;
            cmd_done = ($urandom % 4) == 0;
            cmd_err = ($urandom % 8) == 0;
            xfer_cmd_err = ($urandom % 8) == 0;
            bus_err = ($urandom % 8) == 0;
            wr_en = ($urandom % 3) == 0;
            wr_sel = $urandom % 2;
            wr_data = $urandom % 16;
            wr_mask = $urandom % 16;
            set = {bus_err, xfer_cmd_err, cmd_err, cmd_done};
            m_st = next_st(m_st, set, wr_en, wr_sel, wr_data);
            m_en = next_en(m_en, wr_en, wr_sel, wr_data, wr_mask);
            cyc();
            chk("R2/R3/R10 status", status, m_st);
            chk("R4 enable", enable, m_en);
            chk("R5 irq", irq, |(m_st & m_en));
            chk("R5 pending", pending, m_st != 0);
        end
        quiet(); cyc();

        // R4 masked enable write directed
        wr_en = 1; wr_sel = 0; wr_data = 4'hF; wr_mask = 4'hF; cyc();
        wr_data = 4'h0; wr_mask = 4'b0100; cyc(); quiet();
        chk("R4 masked clear", enable, 4'b1011);
        clear_all();
        chk("R3 clear all", status, 0);

        // R3 mask ignored for status clear
        cmd_err = 1; xfer_cmd_err = 1; cyc(); quiet();
        wr_en = 1; wr_sel = 1; wr_data = 4'b0010; wr_mask = 4'b0000; cyc(); quiet();
        chk("R3 w1c ignores mask", status, 4'b0100);
        // R5 pending with enables off
        wr_en = 1; wr_sel = 0; wr_data = 0; wr_mask = 4'hF; cyc(); quiet();
        chk("R5 pending no enable", pending, 1);
        chk("R5 irq no enable", irq, 0);
        clear_all();

        // R10 set wins over clear
        cmd_err = 1; wr_en = 1; wr_sel = 1; wr_data = 4'b0010; cyc(); quiet();
        chk("R10 set beats clear", status[1], 1);
        clear_all();

        // R6 R7 command timeout, N=3
        cmd_tmo_set = 8'd3; lim = lim_of(8'd3);
        cmd_start = 1; cyc(); quiet();
        chk("R6 idle low after start", idle, 0);
        for (int k = 1; k < lim; k++) begin
            cyc();
            if (k == lim - 1) begin
                chk("R7 no early timeout", status[1], 0);
                chk("R7 still busy", idle, 0);
            end
        end
        cyc();
        chk("R7 timeout flag", status[1], 1);
        chk("R7 idle after timeout", idle, 1);
        clear_all();

        // R6 done ends command
        cmd_start = 1; cyc(); quiet(); cyc();
        cmd_done = 1; cyc(); quiet();
        chk("R6 idle after done", idle, 1);
        chk("R6 done flag", status, 4'b0001);
        clear_all();

        // R11 done on expiry edge
        cmd_tmo_set = 8'd1; lim = lim_of(8'd1);
        cmd_start = 1; cyc(); quiet();
        for (int k = 1; k < lim; k++) cyc();
        cmd_done = 1; cyc(); quiet();
        chk("R11 no timeout on done", status[1], 0);
        chk("R11 done flag", status[0], 1);
        chk("R11 idle", idle, 1);
        clear_all();

        // R8 zero setting on command timer
        cmd_tmo_set = 8'd0; lim = lim_of(8'd0);
        cmd_start = 1; cyc(); quiet();
        for (int k = 1; k < lim; k++) cyc();
        chk("R8 cmd zero no early", status[1], 0);
        cyc();
        chk("R8 cmd zero limit", status[1], 1);
        clear_all();

        // R9 bus timeout, N=2
        bus_tmo_set = 8'd2; lim = lim_of(8'd2);
        bus_busy = 1;
        for (int k = 1; k < lim; k++) cyc();
        chk("R9 bus no early", status[3], 0);
        cyc();
        chk("R9 bus timeout", status[3], 1);
        clear_all();
        repeat (20) cyc();
        chk("R9 once per period", status[3], 0);
        bus_busy = 0; cyc(); bus_busy = 1;
        for (int k = 1; k < lim; k++) cyc();
        chk("R9 restart no early", status[3], 0);
        cyc();
        chk("R9 restart timeout", status[3], 1);
        bus_busy = 0; cyc();
        clear_all();

        // R8 zero setting on bus timer
        bus_tmo_set = 8'd0; lim = lim_of(8'd0);
        bus_busy = 1;
        for (int k = 1; k < lim; k++) cyc();
        chk("R8 bus zero no early", status[3], 0);
        cyc();
        chk("R8 bus zero limit", status[3], 1);
        bus_busy = 0; cyc();

        finished = 1;
        summary();
    end
endmodule